// File: doc/BRIEF.md
# Parallel ADC Host Bus Controller

This block is the host side of a 16-bit shared parallel bus to a sigma-delta converter. The bus uses an active-low chip-select (`cs_n`), a direction select (`rw`, where 0 means read and 1 means write) and an active-low data-ready strobe from the converter. Each data-ready strobe starts a fetch made of two separate chip-select pulses. The first pulse returns the upper 16 bits of the result. The second returns the lower word, and the low byte of that word carries status. The controller joins the two words into a 24-bit sample and reports the status byte on its own port.

Register writes come in from user logic through a ready/valid request. Each write goes out as two chip-select pulses: the register address first, then the register data. All low widths and high gaps are counted in clock cycles, and the clock is taken to be the converter's internal clock or faster. The controller drives the data bus only while a write pulse is active. At all other times its output enable is low, so the bus is left to the converter. If a data-ready strobe arrives while a write is on the bus, it is held and serviced once the write ends. A write request that arrives during a fetch waits until the fetch is finished.

Top module: `adc_pbus_ctrl`

## Requirements
- R1: While reset is held and just after it, `cs_n` is 1, `bus_oe` is 0, `sample_valid` and `wr_done` are 0, and `wr_ready` is 1.
- R2: Every chip-select low pulse of a fetch has `rw`=0, and every pulse of a write has `rw`=1. `rw` changes only while `cs_n` has been high for a whole cycle, so it is stable before `cs_n` falls and until it rises.
- R3: A falling edge on `drdy_n` that is sampled by the clock produces exactly two read pulses. The first returns the upper word and the second returns the lower word.
- R4: The result is reported with a one-cycle `sample_valid` pulse. `sample_data` = {upper word, lower word bits 15:8} and `sample_status` = lower word bits 7:0.
- R5: Each read pulse stays low for exactly RD_WAIT cycles, and the bus is captured in the last of those cycles. `cs_n` stays high for exactly RD_GAP cycles between the two read pulses.
- R6: A write puts the register address on `bus_dout` during the first pulse and the register data during the second pulse.
- R7: Each write pulse stays low for exactly WR_LOW cycles, with WR_GAP high cycles between the two pulses. `wr_done` pulses for one cycle as the data pulse ends.
- R8: A request whose address is outside 1..5 is accepted by the handshake but makes no chip-select pulse and no `wr_done`.
- R9: While a fetch is in progress or pending, `wr_ready` is 0. A write request made during a fetch is carried out after both read pulses.
- R10: A data-ready strobe that arrives during a write is held pending. Its two read pulses follow the write's two pulses and give a correct sample.
- R11: `bus_oe` is 1 only while `cs_n` is 0 and `rw` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at least the converter's internal clock rate |
| rst | input | 1 | Synchronous active-high reset |
| drdy_n | input | 1 | Active-low data-ready strobe from the converter |
| cs_n | output | 1 | Active-low chip-select to the converter |
| rw | output | 1 | Direction select: 0 read, 1 write |
| bus_din | input | 16 | Data bus as seen from the converter |
| bus_dout | output | 16 | Data the controller drives onto the bus |
| bus_oe | output | 1 | Output enable of `bus_dout`; bus released when 0 |
| wr_req | input | 1 | Register write request |
| wr_addr | input | 16 | Register address of the request |
| wr_data | input | 16 | Register data of the request |
| wr_ready | output | 1 | A request is accepted in a cycle with `wr_req` and `wr_ready` both high |
| wr_done | output | 1 | One-cycle pulse when the write has left the bus |
| sample_valid | output | 1 | One-cycle pulse with a new sample |
| sample_data | output | 24 | Joined 24-bit conversion result |
| sample_status | output | 8 | Status byte taken from the lower word |

## Verification
The assertions assume that `drdy_n` is synchronous to `clk` and low across at least one rising edge. They also assume that the converter places read data on `bus_din` within RD_WAIT cycles of `cs_n` falling. The bench's bus model changes `bus_din` as soon as chip-select falls, and it drives the strobe low for three quarters of a clock period around one rising edge. `wr_req` is held until the handshake completes, and the bench never raises it in a way that depends on edge ordering.

// File: rtl/adc_pbus_pkg.sv
package adc_pbus_pkg;

    localparam int BUS_W    = 16;
    localparam int SAMPLE_W = 24;
    localparam int STAT_W   = BUS_W + BUS_W - SAMPLE_W;
    localparam int LO_KEEP  = SAMPLE_W - BUS_W;

    localparam logic [BUS_W-1:0] REG_ADDR_FIRST = 16'd1;
    localparam logic [BUS_W-1:0] REG_ADDR_LAST  = 16'd5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_HI,
        ST_RD_GAP,
        ST_RD_LO,
        ST_WR_SETUP,
        ST_WR_ADDR,
        ST_WR_GAP,
        ST_WR_DATA
    } bus_state_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic [STAT_W-1:0]   status;
    } sample_t;

    function automatic sample_t join_words(input logic [BUS_W-1:0] hi,
                                           input logic [BUS_W-1:0] lo);
        sample_t s;
        s.data   = {hi, lo[BUS_W-1 -: LO_KEEP]};
        s.status = lo[STAT_W-1:0];
        return s;
    endfunction

    function automatic logic reg_addr_ok(input logic [BUS_W-1:0] a);
        return (a >= REG_ADDR_FIRST) && (a <= REG_ADDR_LAST);
    endfunction

    function automatic logic is_cs_low(input bus_state_e s);
        return (s == ST_RD_HI) || (s == ST_RD_LO) ||
               (s == ST_WR_ADDR) || (s == ST_WR_DATA);
    endfunction

endpackage

// File: rtl/adc_pbus_drdy.sv
module adc_pbus_drdy (
    input  logic clk,
    input  logic rst,
    input  logic drdy_n,
    output logic evt
);
    logic drdy_q;

    always_ff @(posedge clk) begin
        if (rst) drdy_q <= 1'b1;
        else     drdy_q <= drdy_n;
    end

    // falling edge of the strobe as seen by this clock
    assign evt = drdy_q & ~drdy_n;

endmodule

// File: rtl/adc_pbus_timer.sv
module adc_pbus_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val - 1'b1;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // a zero-length phase would underflow the counter (R5, R7)
    assert_timer_load_R5: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

endmodule

// File: rtl/adc_pbus_seq.sv
module adc_pbus_seq
    import adc_pbus_pkg::*;
#(
    parameter int CW      = 4,
    parameter int RD_WAIT = 2,
    parameter int RD_GAP  = 1,
    parameter int WR_LOW  = 4,
    parameter int WR_GAP  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             wr_req,
    input  logic [BUS_W-1:0] wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [BUS_W-1:0] bus_din,
    input  logic             t_expired,
    output logic             t_load,
    output logic [CW-1:0]    t_val,
    output logic             cs_n,
    output logic             rw,
    output logic             bus_oe,
    output logic [BUS_W-1:0] bus_dout,
    output logic             wr_ready,
    output logic             wr_done,
    output logic             sample_valid,
    output sample_t          sample
);
    bus_state_e       state, nxt;
    logic             pend;
    logic             rw_q;
    logic [BUS_W-1:0] addr_q, data_q, hi_q;
    logic             sv_q, wd_q;
    sample_t          samp_q;
    logic             accept;

    assign wr_ready = (state == ST_IDLE) && !pend;
    assign accept   = wr_ready && wr_req;

    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (pend)
                    nxt = ST_RD_SETUP;
                else if (wr_req && reg_addr_ok(wr_addr))
                    nxt = ST_WR_SETUP;
            end
            ST_RD_SETUP: begin
                nxt = ST_RD_HI; t_load = 1'b1; t_val = CW'(RD_WAIT);
            end
            ST_RD_HI: if (t_expired) begin
                nxt = ST_RD_GAP; t_load = 1'b1; t_val = CW'(RD_GAP);
            end
            ST_RD_GAP: if (t_expired) begin
                nxt = ST_RD_LO; t_load = 1'b1; t_val = CW'(RD_WAIT);
            end
            ST_RD_LO: if (t_expired) nxt = ST_IDLE;
            ST_WR_SETUP: begin
                nxt = ST_WR_ADDR; t_load = 1'b1; t_val = CW'(WR_LOW);
            end
            ST_WR_ADDR: if (t_expired) begin
                nxt = ST_WR_GAP; t_load = 1'b1; t_val = CW'(WR_GAP);
            end
            ST_WR_GAP: if (t_expired) begin
                nxt = ST_WR_DATA; t_load = 1'b1; t_val = CW'(WR_LOW);
            end
            ST_WR_DATA: if (t_expired) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pend   <= 1'b0;
            rw_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            hi_q   <= '0;
            sv_q   <= 1'b0;
            wd_q   <= 1'b0;
            samp_q <= '0;
        end else begin
            state <= nxt;
            pend  <= evt | (pend & (state != ST_IDLE));
            if (state == ST_IDLE && pend) begin
                rw_q <= 1'b0;
            end else if (accept && reg_addr_ok(wr_addr)) begin
                rw_q   <= 1'b1;
                addr_q <= wr_addr;
                data_q <= wr_data;
            end
            if (state == ST_RD_HI && t_expired)
                hi_q <= bus_din;
            sv_q <= (state == ST_RD_LO) && t_expired;
            if (state == ST_RD_LO && t_expired)
                samp_q <= join_words(hi_q, bus_din);
            wd_q <= (state == ST_WR_DATA) && t_expired;
        end
    end

    assign cs_n         = !is_cs_low(state);
    assign rw           = rw_q;
    assign bus_oe       = (state == ST_WR_ADDR) || (state == ST_WR_DATA);
    assign bus_dout     = (state == ST_WR_ADDR) ? addr_q :
                          (state == ST_WR_DATA) ? data_q : '0;
    assign sample_valid = sv_q;
    assign sample       = samp_q;
    assign wr_done      = wd_q;

    // a held strobe is served as soon as the bus is idle (R10)
    assert_pend_served_R10: assert property (@(posedge clk) disable iff (rst)
        (pend && state == ST_IDLE) |=> (state == ST_RD_SETUP));

    // the first read pulse always follows a setup cycle with rw low (R3)
    assert_read_order_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_SETUP) |=> (state == ST_RD_HI && !rw_q));

endmodule

// File: rtl/adc_pbus_ctrl.sv
module adc_pbus_ctrl
    import adc_pbus_pkg::*;
#(
    parameter int RD_WAIT = 2,
    parameter int RD_GAP  = 1,
    parameter int WR_LOW  = 4,
    parameter int WR_GAP  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                drdy_n,
    output logic                cs_n,
    output logic                rw,
    input  logic [BUS_W-1:0]    bus_din,
    output logic [BUS_W-1:0]    bus_dout,
    output logic                bus_oe,
    input  logic                wr_req,
    input  logic [BUS_W-1:0]    wr_addr,
    input  logic [BUS_W-1:0]    wr_data,
    output logic                wr_ready,
    output logic                wr_done,
    output logic                sample_valid,
    output logic [SAMPLE_W-1:0] sample_data,
    output logic [STAT_W-1:0]   sample_status
);
    localparam int MAX_RD = (RD_WAIT > RD_GAP) ? RD_WAIT : RD_GAP;
    localparam int MAX_WR = (WR_LOW > WR_GAP) ? WR_LOW : WR_GAP;
    localparam int MAX_T  = (MAX_RD > MAX_WR) ? MAX_RD : MAX_WR;
    localparam int CW     = $clog2(MAX_T + 1);

    logic          evt;
    logic          t_load, t_expired;
    logic [CW-1:0] t_val;
    sample_t       sample;

    adc_pbus_drdy u_drdy (
        .clk    (clk),
        .rst    (rst),
        .drdy_n (drdy_n),
        .evt    (evt)
    );

    adc_pbus_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    adc_pbus_seq #(
        .CW(CW), .RD_WAIT(RD_WAIT), .RD_GAP(RD_GAP),
        .WR_LOW(WR_LOW), .WR_GAP(WR_GAP)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .wr_req       (wr_req),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .bus_din      (bus_din),
        .t_expired    (t_expired),
        .t_load       (t_load),
        .t_val        (t_val),
        .cs_n         (cs_n),
        .rw           (rw),
        .bus_oe       (bus_oe),
        .bus_dout     (bus_dout),
        .wr_ready     (wr_ready),
        .wr_done      (wr_done),
        .sample_valid (sample_valid),
        .sample       (sample)
    );

    assign sample_data   = sample.data;
    assign sample_status = sample.status;

    // run-length counter of chip-select low cycles, for width checks
    logic [7:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)                       low_run <= '0;
        else if (!cs_n && low_run != 8'hFF) low_run <= low_run + 1'b1;
        else if (cs_n)                 low_run <= '0;
    end

    assert_rw_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n || !$past(cs_n)) |-> $stable(rw));

    assert_bus_drive_R11: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!cs_n && rw));

    assert_sample_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    assert_write_width_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_n) && rw) |-> (low_run >= WR_LOW));

    assert_read_width_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_n) && !rw) |-> (low_run == RD_WAIT));

endmodule

// File: tb/adc_pbus_ctrl_test.sv
module adc_pbus_ctrl_test;

    localparam int RD_WAIT = 2;
    localparam int RD_GAP  = 1;
    localparam int WR_LOW  = 4;
    localparam int WR_GAP  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        drdy_n = 1'b1;
    logic        cs_n, rw, bus_oe;
    logic [15:0] bus_din = 16'hDEAD;
    logic [15:0] bus_dout;
    logic        wr_req = 1'b0;
    logic [15:0] wr_addr = '0, wr_data = '0;
    logic        wr_ready, wr_done, sample_valid;
    logic [23:0] sample_data;
    logic [7:0]  sample_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    adc_pbus_ctrl #(.RD_WAIT(RD_WAIT), .RD_GAP(RD_GAP),
                    .WR_LOW(WR_LOW), .WR_GAP(WR_GAP)) uut (
        .clk(clk), .rst(rst), .drdy_n(drdy_n), .cs_n(cs_n), .rw(rw),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .wr_done(wr_done), .sample_valid(sample_valid),
        .sample_data(sample_data), .sample_status(sample_status)
    );

    // converter model: upper word on the first read pulse, lower on the second
    logic [15:0] hi_w = '0, lo_w = '0;
    bit          rd_sel = 1'b0;
    always @(cs_n) begin
        if (cs_n) bus_din = 16'hDEAD;
        else if (!rw) begin
            bus_din = rd_sel ? lo_w : hi_w;
            rd_sel  = !rd_sel;
        end
    end

    // pulse log, sampled on falling clock edges
    int  p_rw[16], p_len[16], p_gap[16], p_word[16];
    int  pn = 0, low_run = 0, high_run = 0, cur_word = 0, oe_bad = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_oe && (cs_n || !rw)) oe_bad++;
            if (!cs_n) begin
                if (low_run == 0 && pn < 16) p_gap[pn] = high_run;
                low_run++;
                high_run = 0;
                if (rw && bus_oe) cur_word = int'(bus_dout);
            end else begin
                if (low_run != 0 && pn < 16) begin
                    p_rw[pn] = int'(rw); p_len[pn] = low_run;
                    p_word[pn] = cur_word; pn++;
                end
                low_run = 0;
                high_run++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fire_drdy();
        @(negedge clk);
        drdy_n = 1'b0;
        #15 drdy_n = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic wait_sample(output bit got, output int d, output int s);
        got = 0; d = 0; s = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sample_valid) begin
                got = 1; d = int'(sample_data); s = int'(sample_status);
                break;
            end
        end
        @(negedge clk);
    endtask

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (wr_done) begin got = 1; break; end
        end
        @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(bus_oe == 1'b0, "R1 bus_oe", int'(bus_oe), 0);
        chk(!sample_valid && !wr_done, "R1 pulses", int'(sample_valid), 0);
        chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
    endtask

    task automatic test_read(input logic [15:0] h, input logic [15:0] l);
        bit got; int d, s;
        hi_w = h; lo_w = l; rd_sel = 1'b0; pn = 0;
        fire_drdy();
        wait_sample(got, d, s);
        chk(got, "R4 sample_valid seen", int'(got), 1);
        chk(d == int'({h, l[15:8]}), "R4 sample_data", d, int'({h, l[15:8]}));
        chk(s == int'(l[7:0]), "R4 sample_status", s, int'(l[7:0]));
        chk(pn == 2, "R3 two read pulses", pn, 2);
        chk(p_rw[0] == 0 && p_rw[1] == 0, "R2 rw low on reads", p_rw[1], 0);
        chk(p_len[0] == RD_WAIT && p_len[1] == RD_WAIT, "R5 read width", p_len[1], RD_WAIT);
        chk(p_gap[1] == RD_GAP, "R5 read gap", p_gap[1], RD_GAP);
    endtask

    task automatic test_write(input logic [15:0] a, input logic [15:0] d);
        bit got;
        pn = 0;
        do_write(a, d);
        wait_done(got);
        chk(got, "R7 wr_done", int'(got), 1);
        chk(pn == 2, "R6 two write pulses", pn, 2);
        chk(p_rw[0] == 1 && p_rw[1] == 1, "R2 rw high on writes", p_rw[0], 1);
        chk(p_word[0] == int'(a), "R6 address word", p_word[0], int'(a));
        chk(p_word[1] == int'(d), "R6 data word", p_word[1], int'(d));
        chk(p_len[0] == WR_LOW && p_len[1] == WR_LOW, "R7 write width", p_len[1], WR_LOW);
        chk(p_gap[1] == WR_GAP, "R7 write gap", p_gap[1], WR_GAP);
    endtask

    task automatic test_bad_addr(input logic [15:0] a);
        int dones = 0;
        pn = 0;
        do_write(a, 16'h5A5A);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (wr_done) dones++;
        end
        chk(pn == 0, "R8 no pulse for bad address", pn, 0);
        chk(dones == 0, "R8 no wr_done", dones, 0);
        chk(wr_ready == 1'b1, "R8 ready after reject", int'(wr_ready), 1);
    endtask

    task automatic test_write_during_read();
        bit got_s, got_w; int d, s;
        hi_w = 16'h0F0F; lo_w = 16'hC33C; rd_sel = 1'b0; pn = 0;
        fire_drdy();
        @(negedge clk);
        chk(wr_ready == 1'b0, "R9 ready low while fetch pending", int'(wr_ready), 0);
        fork
            wait_sample(got_s, d, s);
            begin do_write(16'd3, 16'h0102); wait_done(got_w); end
        join
        chk(got_s && d == 24'h0F0FC3 && s == 8'h3C, "R9 sample during contention", d, 24'h0F0FC3);
        chk(pn == 4 && p_rw[0] == 0 && p_rw[1] == 0 && p_rw[2] == 1 && p_rw[3] == 1,
            "R9 reads before write", pn, 4);
        chk(got_w && p_word[3] == 16'h0102, "R9 write data after reads", p_word[3], 16'h0102);
    endtask

    task automatic test_drdy_during_write();
        bit got_s, got_w; int d, s;
        hi_w = 16'h7FFF; lo_w = 16'hFF80; rd_sel = 1'b0; pn = 0;
        fork
            begin do_write(16'd4, 16'h00FF); wait_done(got_w); end
            begin repeat (4) @(negedge clk); fire_drdy(); end
            wait_sample(got_s, d, s);
        join
        chk(got_w, "R10 write finished", int'(got_w), 1);
        chk(got_s && d == 24'h7FFFFF && s == 8'h80, "R10 held fetch sample", d, 24'h7FFFFF);
        chk(pn == 4 && p_rw[0] == 1 && p_rw[1] == 1 && p_rw[2] == 0 && p_rw[3] == 0,
            "R10 write then reads", pn, 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        @(negedge clk) rst = 1'b0;
        test_reset();
        test_read(16'h1234, 16'h56A5);
        test_read(16'h8000, 16'hFF01);
        test_write(16'd2, 16'hBEEF);
        test_write(16'd5, 16'h0001);
        test_bad_addr(16'd0);
        test_bad_addr(16'd6);
        test_write_during_read();
        test_drdy_during_write();
        chk(oe_bad == 0, "R11 bus driven only in write pulses", oe_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule